// File: doc/BRIEF.md
# Oversampling UART Receiver with Idle Qualification

This block decodes an asynchronous, receive-only serial line carrying 8N1 frames: one start bit, eight data bits, no parity and one stop bit. The line rests high, and a drop to low opens a frame. The sender never waits for the receiver, so the block must be able to start listening in the middle of a byte stream and still lock on. It will not accept a start edge until it has seen the line stay high for a whole frame time of ten bits.

Timing comes from an internal sample tick. The tick is a plain clock divider that runs at sixteen times the bit rate. For example, 2400 bit/s needs a tick at 38400 Hz.

Each start edge re-aligns the bit timing, so a small rate mismatch between sender and receiver cannot build up from one byte to the next. Within each bit, five samples near the bit centre are taken and the majority value is kept. A single disturbed sample therefore cannot change the bit.

The block reports each received byte with a one-cycle strobe. A framing-error flag marks a byte whose stop bit read low.

Top module: `uart_idle_rx`

## Requirements
- R1: After reset the outputs `rx_byte`, `rx_valid` and `rx_ferr` are all zero, and an idle line (logic 1) produces no output.
- R2: A sample tick occurs once every `CLK_DIV` clock cycles. One bit period is 16 ticks, so a bit lasts `16*CLK_DIV` clocks.
- R3: After reset, a start bit is accepted only once the line has been high on 160 consecutive ticks (ten bit times). Frames that arrive before that point are ignored.
- R4: In the armed state, a low line seen on a tick is a start edge. That tick is tick 0 of the start bit, and bit timing restarts from there on every frame, including back-to-back frames.
- R5: If the voted start bit reads 1, the edge is treated as a glitch. No output is produced, and the receiver waits for the next start edge without requalifying.
- R6: Each bit value is the majority of the five samples taken on ticks 6, 7, 8, 9 and 10 of that bit. One wrong sample in this window does not change the bit.
- R7: Eight data bits follow the start bit and are received least-significant bit first. The first data bit becomes `rx_byte[0]`.
- R8: `rx_valid` is high for exactly one clock per received byte. `rx_byte` and `rx_ferr` change only on that clock and hold their values until the next byte.
- R9: A stop bit that votes 0 still delivers the byte, with `rx_ferr`=1. The receiver then requalifies the line, requiring 160 consecutive high ticks, before it accepts another start bit.
- R10: `rxd` passes through a two-flop synchronizer before any other logic uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input, idles high |
| rx_byte | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new byte |
| rx_ferr | output | 1 | Stop bit of the last byte read low |

## Verification
On every cycle the assertions check four things:
- the spacing between sample ticks;
- that `rx_valid` lasts a single cycle;
- that the byte and error flag stay stable between strobes;
- that no start edge is accepted unless an independent count has seen the synchronized line high for a full frame time since reset or the last framing error.

Some behaviours can only be shown by the bench's scenarios, and it compares against a behavioural reference every clock:
- rejection of a stream that is joined mid-frame;
- majority voting against a one-sample spike;
- start-glitch rejection;
- bit order;
- re-alignment under a 1.6% rate error.

// File: rtl/uart_idle_rx.sv
module uart_idle_rx #(
  parameter int CLK_DIV   = 4,
  parameter int OVS       = 16,
  parameter int IDLE_BITS = 10,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_ferr
);
  localparam int IDLE_TICKS = IDLE_BITS * OVS;
  localparam int DW = $clog2(CLK_DIV > 1 ? CLK_DIV : 2);
  localparam int IW = $clog2(IDLE_TICKS + 1);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(DATA_BITS + 2);
  localparam logic [DW-1:0] DIV_LAST  = DW'(CLK_DIV - 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_TICKS - 1);
  localparam logic [TW-1:0] T_LAST    = TW'(OVS - 1);
  localparam logic [TW-1:0] V_LO      = TW'(OVS / 2 - 2);
  localparam logic [TW-1:0] V_HI      = TW'(OVS / 2 + 2);
  localparam logic [BW-1:0] B_LASTD   = BW'(DATA_BITS);

  typedef enum logic [1:0] {S_QUAL, S_ARMED, S_RECV} st_t;

  logic [1:0]           sync_q;
  logic [DW-1:0]        div_q;
  logic [IW-1:0]        idle_q;
  logic [TW-1:0]        tcnt;
  logic [BW-1:0]        bidx;
  logic [2:0]           ones;
  logic [DATA_BITS-1:0] shreg;
  st_t                  st;

  logic rx_s, tick, start_hit, in_win, decide, vote;
  logic [TW-1:0] pos;
  logic [2:0]    ones_nx;

  assign rx_s      = sync_q[1];
  assign tick      = (div_q == DIV_LAST);
  assign start_hit = tick && (st == S_ARMED) && !rx_s;
  assign pos       = (tcnt == T_LAST) ? '0 : tcnt + 1'b1;
  assign in_win    = (pos >= V_LO) && (pos <= V_HI);
  assign ones_nx   = ones + 3'(in_win && rx_s);
  assign decide    = (pos == V_HI);
  assign vote      = (ones_nx >= 3'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      div_q  <= tick ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_QUAL;
      idle_q   <= '0;
      tcnt     <= '0;
      bidx     <= '0;
      ones     <= '0;
      shreg    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        case (st)
          S_QUAL: begin
            if (!rx_s) idle_q <= '0;
            else if (idle_q == IDLE_LAST) begin
              st     <= S_ARMED;
              idle_q <= '0;
            end else idle_q <= idle_q + 1'b1;
          end
          S_ARMED: begin
            if (start_hit) begin
              st   <= S_RECV;
              tcnt <= '0;
              bidx <= '0;
              ones <= '0;
            end
          end
          default: begin
            tcnt <= pos;
            ones <= decide ? 3'd0 : ones_nx;
            if (decide) begin
              if (bidx == '0) begin
                if (vote) st <= S_ARMED;
                else bidx <= bidx + 1'b1;
              end else if (bidx <= B_LASTD) begin
                shreg <= {vote, shreg[DATA_BITS-1:1]};
                bidx  <= bidx + 1'b1;
              end else begin
                rx_byte  <= shreg;
                rx_valid <= 1'b1;
                rx_ferr  <= !vote;
                st       <= vote ? S_ARMED : S_QUAL;
                idle_q   <= '0;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_idle_rx_chk.sv
module uart_idle_rx_chk #(
  parameter int CLK_DIV    = 4,
  parameter int IDLE_TICKS = 160,
  parameter int DATA_BITS  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 rx_s,
  input logic                 start_hit,
  input logic [DATA_BITS-1:0] rx_byte,
  input logic                 rx_valid,
  input logic                 rx_ferr
);
  int   gap_q;
  int   hi_run;
  logic seen_tick;
  logic qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= 0;
      seen_tick <= 1'b0;
      hi_run    <= 0;
      qual_q    <= 1'b0;
    end else begin
      gap_q <= tick ? 1 : gap_q + 1;
      if (tick) seen_tick <= 1'b1;
      if (tick) hi_run <= rx_s ? ((hi_run < IDLE_TICKS) ? hi_run + 1 : hi_run) : 0;
      if (rx_valid && rx_ferr) qual_q <= 1'b0;
      else if (tick && rx_s && hi_run >= IDLE_TICKS - 1) qual_q <= 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_tick) |-> (gap_q == CLK_DIV)); // R2

  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |-> qual_q); // R3

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R8

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte)); // R8

  AST_FERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_ferr)); // R9
endmodule

bind uart_idle_rx uart_idle_rx_chk #(
  .CLK_DIV(CLK_DIV), .IDLE_TICKS(IDLE_TICKS), .DATA_BITS(DATA_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s), .start_hit(start_hit),
  .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
);

// File: tb/uart_idle_rx_tb.sv
`timescale 1ns/1ps
module uart_idle_rx_tb;
  localparam int DIV  = 4;
  localparam int BITC = DIV * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic [7:0] rx_byte;
  logic rx_valid, rx_ferr;

  int checks = 0;
  int errors = 0;
  logic [8:0] rxq[$];

  always #2 clk = ~clk;

  uart_idle_rx #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
  );

  int ms1, ms2, dc, mst, midle, mt, mb, mones;
  logic [7:0] msh, mbyte;
  bit mval, mferr;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms1 = 1; ms2 = 1; dc = 0; mst = 0; midle = 0; mt = 0; mb = 0; mones = 0;
      msh = 0; mbyte = 0; mval = 0; mferr = 0;
    end else begin
      int s, pos;
      bit tk, v;
      s = ms2; ms2 = ms1; ms1 = int'(rxd);
      tk = (dc == DIV - 1);
      dc = tk ? 0 : dc + 1;
      mval = 0;
      if (tk) begin
        if (mst == 0) begin
          if (s == 0) midle = 0;
          else if (midle == 159) begin mst = 1; midle = 0; end
          else midle++;
        end else if (mst == 1) begin
          if (s == 0) begin mst = 2; mt = 0; mb = 0; mones = 0; end
        end else begin
          pos = (mt + 1) % 16;
          if (pos >= 6 && pos <= 10 && s == 1) mones++;
          mt = pos;
          if (pos == 10) begin
            v = (mones >= 3);
            mones = 0;
            if (mb == 0) begin
              if (v) mst = 1; else mb = 1;
            end else if (mb <= 8) begin
              msh = {v, msh[7:1]};
              mb++;
            end else begin
              mbyte = msh; mval = 1; mferr = !v;
              mst = v ? 1 : 0; midle = 0;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rx_valid !== mval || rx_byte !== mbyte || rx_ferr !== mferr) begin
        errors++;
        $display("FAIL R2/R8/R10 cycle model: got v=%0b b=%02h e=%0b exp v=%0b b=%02h e=%0b",
                 rx_valid, rx_byte, rx_ferr, mval, mbyte, mferr);
      end
      if (rx_valid) rxq.push_back({rx_ferr, rx_byte});
    end
  end

  task automatic send_bit(input logic b, input int len);
    rxd = b;
    repeat (len) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stopb, input int len);
    send_bit(1'b0, len);
    for (int i = 0; i < 8; i++) send_bit(d[i], len);
    send_bit(stopb, len);
  endtask

  task automatic send_spiked(input logic [7:0] d, input int bitn);
    send_bit(1'b0, BITC);
    for (int i = 0; i < 8; i++) begin
      if (i == bitn) begin
        send_bit(d[i], 30);
        send_bit(~d[i], 4);
        send_bit(d[i], BITC - 34);
      end else send_bit(d[i], BITC);
    end
    send_bit(1'b1, BITC);
  endtask

  task automatic idle_bits(input int n);
    send_bit(1'b1, n * BITC);
  endtask

  task automatic expect_rx(input logic [7:0] d, input logic e, input string tag);
    checks++;
    if (rxq.size() == 0) begin
      errors++;
      $display("FAIL %s: got nothing exp byte=%02h ferr=%0b", tag, d, e);
    end else begin
      logic [8:0] g;
      g = rxq.pop_front();
      if (g !== {e, d}) begin
        errors++;
        $display("FAIL %s: got byte=%02h ferr=%0b exp byte=%02h ferr=%0b", tag, g[7:0], g[8], d, e);
      end
    end
  endtask

  task automatic expect_none(input string tag);
    checks++;
    if (rxq.size() != 0) begin
      errors++;
      $display("FAIL %s: got %0d bytes (first %03h) exp 0", tag, rxq.size(), rxq[0]);
      rxq.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    checks++;
    if (rx_byte !== 8'h00 || rx_valid !== 1'b0 || rx_ferr !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got b=%02h v=%0b e=%0b exp 0 0 0", rx_byte, rx_valid, rx_ferr);
    end
    rst_n = 1'b1;

    // R3: stream joined mid-traffic is ignored until ten idle bits
    idle_bits(3);
    send_frame(8'h00, 1'b1, BITC);
    send_frame(8'h55, 1'b1, BITC);
    send_frame(8'h0F, 1'b1, BITC);
    idle_bits(2);
    expect_none("R3 early frames");
    idle_bits(12);
    expect_none("R1 idle line");
    send_frame(8'hA5, 1'b1, BITC);
    idle_bits(1);
    expect_rx(8'hA5, 1'b0, "R3 first qualified byte");

    // R7: bit order; R4 back-to-back realign
    send_frame(8'h01, 1'b1, BITC);
    send_frame(8'h80, 1'b1, BITC);
    send_frame(8'h3C, 1'b1, BITC);
    send_frame(8'hC3, 1'b1, BITC);
    send_frame(8'hFF, 1'b1, BITC);
    send_frame(8'h00, 1'b1, BITC);
    idle_bits(2);
    expect_rx(8'h01, 1'b0, "R7 lsb first");
    expect_rx(8'h80, 1'b0, "R7 msb last");
    expect_rx(8'h3C, 1'b0, "R4 back-to-back");
    expect_rx(8'hC3, 1'b0, "R4 back-to-back");
    expect_rx(8'hFF, 1'b0, "R2 all ones");
    expect_rx(8'h00, 1'b0, "R2 all zeros");

    // R4: sender 1.6% fast, realigned each frame
    send_frame(8'h69, 1'b1, BITC - 1);
    send_frame(8'h96, 1'b1, BITC - 1);
    send_frame(8'hE7, 1'b1, BITC - 1);
    idle_bits(2);
    expect_rx(8'h69, 1'b0, "R4 fast sender");
    expect_rx(8'h96, 1'b0, "R4 fast sender");
    expect_rx(8'hE7, 1'b0, "R4 fast sender");

    // R5: short low glitch
    send_bit(1'b0, 12);
    idle_bits(2);
    expect_none("R5 start glitch");
    send_frame(8'h5A, 1'b1, BITC);
    idle_bits(1);
    expect_rx(8'h5A, 1'b0, "R5 after glitch");

    // R6: single-sample spikes inside vote window
    send_spiked(8'h00, 3);
    send_spiked(8'hFF, 6);
    idle_bits(2);
    expect_rx(8'h00, 1'b0, "R6 high spike");
    expect_rx(8'hFF, 1'b0, "R6 low spike");

    // R9: framing error then requalification
    send_frame(8'h96, 1'b0, BITC);
    idle_bits(2);
    send_frame(8'h11, 1'b1, BITC);
    idle_bits(2);
    expect_rx(8'h96, 1'b1, "R9 framing error");
    expect_none("R9 no arm before idle");
    idle_bits(11);
    send_frame(8'h22, 1'b1, BITC);
    idle_bits(1);
    expect_rx(8'h22, 1'b0, "R9 rearmed");
    expect_none("R8 single strobe per byte");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule